// File: doc/BRIEF.md
# Byte-Wide Converter Register Interface

This block is the host-facing register file of a data converter that talks over an 8-bit parallel bus. Every access moves a 16-bit word as two byte strobes, low byte first. On a write, the two top bits of the assembled word name the target register and the 14 bits below them are stored there. On a read, the source is chosen by a read-select field held in the write-only control register. That selection stays in force until the control register is written again.

The register set has five parts. The control register can only be written. The conversion result comes in on a 12-bit input and can only be read. The status word comes in on a 16-bit input and can only be read. The test register can be written and read. A bank of ten calibration registers can be written and read. A calibration-select field in the control register picks a group in that bank: all ten registers, gain and offset, offset alone, or gain alone. Successive calibration word accesses step through the chosen group and wrap at its end. Index 0 is gain, index 1 is offset, and indexes 2 to 9 are the trim registers.

Top module: `cvt_reg_if`

## Requirements
- R1: After reset, both byte phases are low, read-select is 00 and calibration-select is 00, so the first word read returns the conversion result without any prior write.
- R2: A write word is sent as its bits 7:0 on the first strobe and its bits 15:8 on the second strobe. In each byte, wdata_i[0] is the least significant bit.
- R3: No register changes on the first byte of a write. The target is updated only on the strobe that carries the high byte.
- R4: A write word whose bits 15:14 are 00 is taken from the bus and changes no register. Bits 15:14 equal to 01 write the test register, 10 writes the current calibration register, and 11 writes the control register.
- R5: Read-select (control bits 7:6) returns the conversion result for 00, the test register for 01, the calibration registers for 10 and the status input for 11.
- R6: The read selection is sticky. Writes to other registers do not change it, and any number of reads come from the same source.
- R7: A result read returns four zero bits above the 12-bit result. All 16 bits are captured on the low-byte read, so the high byte belongs to the same sample even if result_i changes between the two strobes.
- R8: The test register stores word bits 13:0 and reads back with bits 15:14 as zero.
- R9: The calibration-select field (control bits 1:0) selects one of four groups: 00 covers indexes 0 to 9, 01 covers 0 to 1, 10 covers index 1 only, and 11 covers index 0 only. A control write moves the pointer to the first index of the new group. Each completed calibration word write or read moves it one step, wrapping inside the group.
- R10: A status read returns all 16 bits of status_i.
- R11: Read and write keep separate byte-phase toggles. A read strobe between the two bytes of a write does not disturb how the write word is assembled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write byte strobe, one cycle per byte |
| wdata_i | input | 8 | Write byte |
| rd_en_i | input | 1 | Read byte strobe, one cycle per byte |
| rdata_o | output | 8 | Read byte, valid in the cycle of rd_en_i |
| result_i | input | 12 | Latest conversion result |
| status_i | input | 16 | Status word |

## Verification
The bench aims at the points where the two byte phases can come apart.

- **Half-finished write.** A design that commits on the first byte would show a mixed value when the test register is read after only the low byte has been sent.
- **Read inside a write.** A design with one shared phase toggle would assemble a corrupted word when a read strobe falls between the two write bytes.
- **Result changing mid-read.** The result input changes between the two read strobes. Without the low-byte capture, the word would mix two conversions.
- **Calibration pointer.** The bench walks every calibration group across its wrap point and rewrites the control register to restart the pointer. Off-by-one wrap logic or a missing restart would return values in the wrong order.

// File: rtl/cvt_reg_pkg.sv
package cvt_reg_pkg;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 2 * BYTE_W;
  localparam int DATA_W  = WORD_W - 2;
  localparam int RES_W   = 12;
  localparam int NUM_CAL = 10;
  localparam int CAL_IW  = $clog2(NUM_CAL);
  localparam int RSEL_LSB = 6;
  localparam int CSEL_LSB = 0;

  typedef enum logic [1:0] {
    WA_NONE = 2'b00,
    WA_TEST = 2'b01,
    WA_CAL  = 2'b10,
    WA_CTRL = 2'b11
  } waddr_e;

  typedef enum logic [1:0] {
    RS_RESULT = 2'b00,
    RS_TEST   = 2'b01,
    RS_CAL    = 2'b10,
    RS_STATUS = 2'b11
  } rsel_e;
endpackage

// File: rtl/cvt_byte_phase.sv
module cvt_byte_phase (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  output logic hi_o
);
  logic hi_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hi_q <= 1'b0;
    else if (step_i) hi_q <= ~hi_q;
  end
  assign hi_o = hi_q;
endmodule

// File: rtl/cvt_cal_bank.sv
module cvt_cal_bank #(
  parameter int NUM = 10,
  parameter int DW  = 14,
  parameter int IW  = $clog2(NUM)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    grp_i,
  input  logic          restart_i,
  input  logic [1:0]    restart_grp_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          adv_i,
  output logic [DW-1:0] rdata_o,
  output logic [IW-1:0] ptr_o
);
  localparam logic [IW-1:0] IDX_GAIN = '0;
  localparam logic [IW-1:0] IDX_OFFS = IW'(1);
  localparam logic [IW-1:0] IDX_LAST = IW'(NUM - 1);

  logic [IW-1:0] ptr_q, grp_first, grp_last, rs_first;
  logic [DW-1:0] regs_q [NUM];

  function automatic logic [IW-1:0] first_of(input logic [1:0] g);
    return (g == 2'b10) ? IDX_OFFS : IDX_GAIN;
  endfunction

  always_comb begin
    grp_first = first_of(grp_i);
    rs_first  = first_of(restart_grp_i);
    unique case (grp_i)
      2'b00:   grp_last = IDX_LAST;
      2'b01:   grp_last = IDX_OFFS;
      2'b10:   grp_last = IDX_OFFS;
      default: grp_last = IDX_GAIN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            ptr_q <= '0;
    else if (restart_i)     ptr_q <= rs_first;
    else if (we_i || adv_i) ptr_q <= (ptr_q == grp_last) ? grp_first : ptr_q + IW'(1);
  end

  for (genvar i = 0; i < NUM; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          regs_q[i] <= '0;
      else if (we_i && ptr_q == IW'(i))     regs_q[i] <= wdata_i;
    end
  end

  assign rdata_o = regs_q[ptr_q];
  assign ptr_o   = ptr_q;
endmodule

// File: rtl/cvt_reg_if.sv
module cvt_reg_if
  import cvt_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              rd_en_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic [RES_W-1:0]  result_i,
  input  logic [WORD_W-1:0] status_i
);
  logic              wr_hi, rd_hi;
  logic [BYTE_W-1:0] lo_q, hold_q;
  logic [WORD_W-1:0] word, rd_word;
  logic [DATA_W-1:0] test_q, cal_rd;
  logic [1:0]        rsel_q, csel_q;
  logic [CAL_IW-1:0] cal_ptr;
  waddr_e            waddr;
  rsel_e             rsel;
  logic              commit, ctrl_we, cal_we, cal_adv;

  cvt_byte_phase u_wr_phase (.clk_i, .rst_ni, .step_i(wr_en_i), .hi_o(wr_hi));
  cvt_byte_phase u_rd_phase (.clk_i, .rst_ni, .step_i(rd_en_i), .hi_o(rd_hi));

  assign word    = {wdata_i, lo_q};
  assign waddr   = waddr_e'(word[WORD_W-1 -: 2]);
  assign commit  = wr_en_i && wr_hi;
  assign ctrl_we = commit && waddr == WA_CTRL;
  assign cal_we  = commit && waddr == WA_CAL;
  assign rsel    = rsel_e'(rsel_q);
  assign cal_adv = rd_en_i && rd_hi && rsel == RS_CAL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      test_q <= '0;
      rsel_q <= 2'b00;
      csel_q <= 2'b00;
    end else begin
      if (wr_en_i && !wr_hi) lo_q <= wdata_i;
      if (commit && waddr == WA_TEST) test_q <= word[DATA_W-1:0];
      if (ctrl_we) begin
        rsel_q <= word[RSEL_LSB +: 2];
        csel_q <= word[CSEL_LSB +: 2];
      end
    end
  end

  cvt_cal_bank #(.NUM(NUM_CAL), .DW(DATA_W), .IW(CAL_IW)) u_cal (
    .clk_i, .rst_ni,
    .grp_i(csel_q),
    .restart_i(ctrl_we),
    .restart_grp_i(word[CSEL_LSB +: 2]),
    .we_i(cal_we),
    .wdata_i(word[DATA_W-1:0]),
    .adv_i(cal_adv),
    .rdata_o(cal_rd),
    .ptr_o(cal_ptr)
  );

  always_comb begin
    unique case (rsel)
      RS_RESULT: rd_word = {{(WORD_W-RES_W){1'b0}}, result_i};
      RS_TEST:   rd_word = {2'b00, test_q};
      RS_CAL:    rd_word = {2'b00, cal_rd};
      default:   rd_word = status_i;
    endcase
  end

  // whole word captured on the low-byte read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                hold_q <= '0;
    else if (rd_en_i && !rd_hi) hold_q <= rd_word[WORD_W-1:BYTE_W];
  end

  assign rdata_o = rd_hi ? hold_q : rd_word[BYTE_W-1:0];
endmodule

// File: rtl/cvt_reg_if_chk.sv
module cvt_reg_if_chk
  import cvt_reg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [BYTE_W-1:0] wdata_i,
  input logic [BYTE_W-1:0] rdata_o,
  input logic              wr_hi,
  input logic              rd_hi,
  input logic [1:0]        rsel_q,
  input logic [1:0]        csel_q,
  input logic [DATA_W-1:0] test_q,
  input logic [CAL_IW-1:0] cal_ptr
);
  assert_first_byte_inert_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_hi) |=> $stable(rsel_q) && $stable(csel_q) && $stable(test_q));

  assert_null_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_hi && wdata_i[7:6] == 2'b00) |=> $stable(rsel_q) && $stable(test_q));

  assert_result_pad_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsel_q == 2'b00 && rd_hi) |-> rdata_o[7:4] == 4'h0);

  assert_test_pad_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsel_q == 2'b01 && rd_hi) |-> rdata_o[7:6] == 2'b00);

  assert_cal_ptr_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_ptr < CAL_IW'(NUM_CAL));

  assert_wr_phase_indep_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i) |=> wr_hi == $past(wr_hi));

  assert_rd_phase_indep_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !rd_en_i) |=> rd_hi == $past(rd_hi));
endmodule

bind cvt_reg_if cvt_reg_if_chk u_chk (
  .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .wdata_i, .rdata_o,
  .wr_hi, .rd_hi, .rsel_q, .csel_q, .test_q, .cal_ptr
);

// File: tb/tb_cvt_reg_if.sv
module tb_cvt_reg_if;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic        rd_en_i = 1'b0;
  logic [7:0]  rdata_o;
  logic [11:0] result_i = '0;
  logic [15:0] status_i = '0;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk_i = ~clk_i;

  cvt_reg_if dut (.clk_i, .rst_ni, .wr_en_i, .wdata_i, .rd_en_i, .rdata_o, .result_i, .status_i);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] b);
    @(negedge clk_i); wr_en_i = 1'b1; wdata_i = b;
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  task automatic wr_word(input logic [15:0] w);
    wr_byte(w[7:0]); wr_byte(w[15:8]);
  endtask

  task automatic rd_byte(output logic [7:0] b);
    @(negedge clk_i); rd_en_i = 1'b1; #1 b = rdata_o;
    @(negedge clk_i); rd_en_i = 1'b0;
  endtask

  task automatic rd_word(output logic [15:0] w);
    logic [7:0] lo, hi;
    rd_byte(lo); rd_byte(hi); w = {hi, lo};
  endtask

  task automatic set_ctrl(input logic [1:0] rs, input logic [1:0] cs);
    wr_word({2'b11, 6'b0, rs, 4'b0, cs});
  endtask

  task automatic t_reset;
    logic [15:0] w;
    result_i = 12'hABC;
    rd_word(w); check("R1 default read of result", w, 16'h0ABC);
  endtask

  task automatic t_test_rw;
    logic [15:0] w;
    wr_word({2'b01, 14'h2A5C});
    set_ctrl(2'b01, 2'b00);
    rd_word(w); check("R2 R8 test readback", w, 16'h2A5C);
    wr_word(16'h7FFF);
    rd_word(w); check("R8 test upper bits read zero", w, 16'h3FFF);
  endtask

  task automatic t_partial;
    logic [15:0] w;
    logic [15:0] nw = {2'b01, 14'h1357};
    wr_byte(nw[7:0]);
    rd_word(w); check("R3 no update after low byte", w, 16'h3FFF);
    wr_byte(nw[15:8]);
    rd_word(w); check("R11 R3 word after interleaved read", w, 16'h1357);
  endtask

  task automatic t_addr00;
    logic [15:0] w;
    wr_word(16'h0081);
    rd_word(w); check("R4 null address leaves test and select", w, 16'h1357);
  endtask

  task automatic t_sticky;
    logic [15:0] w;
    wr_word({2'b01, 14'h0C0F});
    wr_word({2'b10, 14'h00C0});
    rd_word(w); check("R6 select sticky 1", w, 16'h0C0F);
    rd_word(w); check("R6 select sticky 2", w, 16'h0C0F);
  endtask

  task automatic t_result;
    logic [7:0] lo, hi;
    logic [15:0] w;
    set_ctrl(2'b00, 2'b00);
    result_i = 12'h123;
    rd_byte(lo);
    result_i = 12'hFED;
    rd_byte(hi);
    check("R7 R5 word from one sample", {hi, lo}, 16'h0123);
    rd_word(w); check("R7 next sample zero padded", w, 16'h0FED);
  endtask

  task automatic t_status;
    logic [15:0] w;
    status_i = 16'hC3A5;
    set_ctrl(2'b11, 2'b00);
    rd_word(w); check("R10 R5 status read", w, 16'hC3A5);
  endtask

  task automatic t_cal;
    logic [15:0] w;
    set_ctrl(2'b10, 2'b00);
    for (int i = 0; i < 10; i++) wr_word({2'b10, 14'h100 + 14'(i)});
    set_ctrl(2'b10, 2'b00);
    for (int i = 0; i < 10; i++) begin
      rd_word(w); check("R9 full group order", w, 16'h100 + 16'(i));
    end
    rd_word(w); check("R9 full group wrap", w, 16'h0100);
    set_ctrl(2'b10, 2'b10);
    wr_word({2'b10, 14'h3333});
    rd_word(w); check("R9 offset group", w, 16'h3333);
    rd_word(w); check("R9 offset group wrap", w, 16'h3333);
    set_ctrl(2'b10, 2'b11);
    rd_word(w); check("R9 gain group", w, 16'h0100);
    set_ctrl(2'b10, 2'b01);
    rd_word(w); check("R9 pair group gain", w, 16'h0100);
    rd_word(w); check("R9 pair group offset", w, 16'h3333);
    rd_word(w); check("R9 pair group wrap", w, 16'h0100);
    set_ctrl(2'b10, 2'b00);
    rd_word(w); rd_word(w); rd_word(w);
    check("R9 trim untouched by group writes", w, 16'h0102);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset;
    t_test_rw;
    t_partial;
    t_addr00;
    t_sticky;
    t_result;
    t_status;
    t_cal;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule